// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block gives two agents, a left port and a right port, a bank of single-bit ownership tokens for guarding shared resources. Each port addresses one token by a small index and either writes to it, asking for or giving up the token, or reads it back. The value read is seen from that port's own side. It is 0 when this port holds the token and 1 when the token is free or held by the other port.

Only the current holder can change a held token. A request from the other side while the token is held is remembered. The moment the holder gives the token up, that request is granted. When both ports ask for a free token in the same cycle, the left port wins and the right port's request is kept waiting. Read data is registered. A read answers the token state as it was at the start of that cycle and then holds until the next read on the same port.

Top module: `semb_bank`

## Requirements
- R1: After reset all tokens are free, and both read registers hold all ones.
- R2: A port acts only in a cycle where its select input is 1 and its memory enable input is 0. In any other cycle, its write leaves every token unchanged and its read register keeps its value.
- R3: The token index is taken from address bits 2:0. Every higher address bit has no effect.
- R4: A write uses data bit 0 alone. A value of 0 asks for the token, and 1 gives it up or withdraws a waiting request. All other data bits are ignored.
- R5: After a port takes a free token, that port reads 0 at that index and the other port reads 1.
- R6: A write of 0 from the port that does not hold the token leaves the holder unchanged.
- R7: If the non-holder wrote 0 while the token was held, it becomes holder when the holder writes 1. Its read shows 0 from the next read on.
- R8: A holder that writes 1 with no request waiting frees the token, and both ports then read 1.
- R9: When both ports write 0 to the same free token in one cycle, the left port gets it and the right request waits. A later release by the left hands the token to the right.
- R10: A waiting request is withdrawn when its own port writes 1 to that index. After that, a release by the holder frees the token.
- R11: A read puts the token's view on every data bit, so the word is all zeros or all ones. The result appears in the read register one clock after the read cycle. It reflects the state before any write in that same cycle, and it is not changed by later writes.
- R12: A write to one index never changes any other index.
- R13: If, in one cycle, the holder writes 1 and the other port writes 0 to the same token, the other port becomes holder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_l | input | 1 | Left semaphore select |
| mem_en_l | input | 1 | Left memory enable; must be 0 for a semaphore access |
| wr_l | input | 1 | Left write (1) or read (0) |
| addr_l | input | ADDR_W | Left address; bits 2:0 pick the token |
| wdata_l | input | DATA_W | Left write data; bit 0 used |
| rdata_l | output | DATA_W | Left registered read data |
| sel_r | input | 1 | Right semaphore select |
| mem_en_r | input | 1 | Right memory enable; must be 0 for a semaphore access |
| wr_r | input | 1 | Right write (1) or read (0) |
| addr_r | input | ADDR_W | Right address; bits 2:0 pick the token |
| wdata_r | input | DATA_W | Right write data; bit 0 used |
| rdata_r | output | DATA_W | Right registered read data |

## Verification
The assertions expect reset to be held high from the first clock edge. They expect every control input to have a known value in every cycle after reset. The stimulus meets this by starting with reset asserted. Every input is driven to a defined value on the falling edge, including cycles where a port is idle with its select low. A sweep driven by a shift register mixes memory-enable, select, read, write and out-of-range address bits. Its indices are confined to four tokens, so that collisions, queued requests and same-cycle races happen often, and each step is compared against an arithmetic model of the token rules.

// File: rtl/semb_pkg.sv
package semb_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    // one port's write intent aimed at one token
    typedef struct packed {
        logic take;
        logic drop;
    } wr_cmd_t;

    typedef struct packed {
        owner_e owner;
        logic   wait_l;
        logic   wait_r;
    } cell_st_t;

    localparam cell_st_t CELL_RESET = '{owner: OWN_NONE, wait_l: 1'b0, wait_r: 1'b0};

    function automatic cell_st_t cell_next(cell_st_t cur, wr_cmd_t cl, wr_cmd_t cr);
        cell_st_t nx;
        nx = cur;
        case (cur.owner)
            OWN_NONE: begin
                nx.wait_l = 1'b0;
                nx.wait_r = 1'b0;
                if (cl.take) begin
                    nx.owner  = OWN_LEFT;
                    nx.wait_r = cr.take;
                end else if (cr.take) begin
                    nx.owner = OWN_RIGHT;
                end
            end
            OWN_LEFT: begin
                nx.wait_l = 1'b0;
                if (cr.take)      nx.wait_r = 1'b1;
                else if (cr.drop) nx.wait_r = 1'b0;
                if (cl.drop) begin
                    if (nx.wait_r) begin
                        nx.owner  = OWN_RIGHT;
                        nx.wait_r = 1'b0;
                    end else begin
                        nx.owner = OWN_NONE;
                    end
                end
            end
            OWN_RIGHT: begin
                nx.wait_r = 1'b0;
                if (cl.take)      nx.wait_l = 1'b1;
                else if (cl.drop) nx.wait_l = 1'b0;
                if (cr.drop) begin
                    if (nx.wait_l) begin
                        nx.owner  = OWN_LEFT;
                        nx.wait_l = 1'b0;
                    end else begin
                        nx.owner = OWN_NONE;
                    end
                end
            end
            default: nx = CELL_RESET;
        endcase
        return nx;
    endfunction

    // 0 when the asking side holds the token, 1 otherwise
    function automatic logic side_view(owner_e o, logic is_left);
        if (is_left) return (o != OWN_LEFT);
        return (o != OWN_RIGHT);
    endfunction

endpackage

// File: rtl/semb_port_dec.sv
module semb_port_dec
    import semb_pkg::*;
#(
    parameter int NUM_SEM = 8,
    parameter int IDX_W   = 3
) (
    input  logic                  sel,
    input  logic                  mem_en,
    input  logic                  wr,
    input  logic [IDX_W-1:0]      idx,
    input  logic                  bit0,
    output logic                  rd_en,
    output wr_cmd_t [NUM_SEM-1:0] cmds
);
    logic acc;

    always_comb begin
        acc   = sel & ~mem_en;
        rd_en = acc & ~wr;
        for (int k = 0; k < NUM_SEM; k++) begin
            cmds[k].take = acc & wr & (idx == IDX_W'(k)) & ~bit0;
            cmds[k].drop = acc & wr & (idx == IDX_W'(k)) &  bit0;
        end
    end
endmodule

// File: rtl/semb_cell.sv
module semb_cell
    import semb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_cmd_t cmd_l,
    input  wr_cmd_t cmd_r,
    output logic    view_l,
    output logic    view_r
);
    cell_st_t st;

    always_ff @(posedge clk) begin
        if (rst) st <= CELL_RESET;
        else     st <= cell_next(st, cmd_l, cmd_r);
    end

    assign view_l = side_view(st.owner, 1'b1);
    assign view_r = side_view(st.owner, 1'b0);
endmodule

// File: rtl/semb_rd_reg.sv
module semb_rd_reg #(
    parameter int NUM_SEM = 8,
    parameter int IDX_W   = 3,
    parameter int DATA_W  = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic [IDX_W-1:0]   idx,
    input  logic [NUM_SEM-1:0] views,
    output logic [DATA_W-1:0]  rdata
);
    always_ff @(posedge clk) begin
        if (rst)        rdata <= '1;
        else if (rd_en) rdata <= {DATA_W{views[idx]}};
    end
endmodule

// File: rtl/semb_bank.sv
module semb_bank
    import semb_pkg::*;
#(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 14,
    parameter int DATA_W  = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_l,
    input  logic              mem_en_l,
    input  logic              wr_l,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [DATA_W-1:0] wdata_l,
    output logic [DATA_W-1:0] rdata_l,
    input  logic              sel_r,
    input  logic              mem_en_r,
    input  logic              wr_r,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic [DATA_W-1:0] wdata_r,
    output logic [DATA_W-1:0] rdata_r
);
    localparam int IDX_W = $clog2(NUM_SEM);

    wr_cmd_t [NUM_SEM-1:0] cmds_l;
    wr_cmd_t [NUM_SEM-1:0] cmds_r;
    logic                  rd_en_l;
    logic                  rd_en_r;
    logic [NUM_SEM-1:0]    sem_view_l;
    logic [NUM_SEM-1:0]    sem_view_r;

    // address bits above the index and data bits above bit 0 carry no meaning here
    logic unused_hi;
    assign unused_hi = ^{addr_l[ADDR_W-1:IDX_W], wdata_l[DATA_W-1:1],
                         addr_r[ADDR_W-1:IDX_W], wdata_r[DATA_W-1:1]};

    semb_port_dec #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) dec_l_i (
        .sel(sel_l), .mem_en(mem_en_l), .wr(wr_l), .idx(addr_l[IDX_W-1:0]),
        .bit0(wdata_l[0]), .rd_en(rd_en_l), .cmds(cmds_l)
    );

    semb_port_dec #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) dec_r_i (
        .sel(sel_r), .mem_en(mem_en_r), .wr(wr_r), .idx(addr_r[IDX_W-1:0]),
        .bit0(wdata_r[0]), .rd_en(rd_en_r), .cmds(cmds_r)
    );

    for (genvar k = 0; k < NUM_SEM; k++) begin : g_cell
        semb_cell cell_i (
            .clk(clk), .rst(rst), .cmd_l(cmds_l[k]), .cmd_r(cmds_r[k]),
            .view_l(sem_view_l[k]), .view_r(sem_view_r[k])
        );
    end

    semb_rd_reg #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W), .DATA_W(DATA_W)) rd_l_i (
        .clk(clk), .rst(rst), .rd_en(rd_en_l), .idx(addr_l[IDX_W-1:0]),
        .views(sem_view_l), .rdata(rdata_l)
    );

    semb_rd_reg #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W), .DATA_W(DATA_W)) rd_r_i (
        .clk(clk), .rst(rst), .rd_en(rd_en_r), .idx(addr_r[IDX_W-1:0]),
        .views(sem_view_r), .rdata(rdata_r)
    );
endmodule

// File: rtl/semb_chk.sv
module semb_chk #(
    parameter int NUM_SEM = 8,
    parameter int IDX_W   = 3,
    parameter int DATA_W  = 9
) (
    input logic               clk,
    input logic               rst,
    input logic               acc_l,
    input logic               wr_l,
    input logic [IDX_W-1:0]   idx_l,
    input logic               wd0_l,
    input logic               acc_r,
    input logic               wr_r,
    input logic [IDX_W-1:0]   idx_r,
    input logic               wd0_r,
    input logic [NUM_SEM-1:0] view_l,
    input logic [NUM_SEM-1:0] view_r,
    input logic [DATA_W-1:0]  rdata_l,
    input logic [DATA_W-1:0]  rdata_r
);
    AST_RESET_READS_ONES: assert property (@(posedge clk)
        rst |=> (rdata_l == '1 && rdata_r == '1)); // R1

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!acc_l && !acc_r) |=> ($stable(view_l) && $stable(view_r)
                                && $stable(rdata_l) && $stable(rdata_r))); // R2

    AST_WORD_UNIFORM: assert property (@(posedge clk) disable iff (rst)
        (rdata_l == '0 || rdata_l == '1) && (rdata_r == '0 || rdata_r == '1)); // R11

    for (genvar k = 0; k < NUM_SEM; k++) begin : g_k
        AST_FREE_GOES_LEFT: assert property (@(posedge clk) disable iff (rst)
            (acc_l && wr_l && !wd0_l && idx_l == IDX_W'(k) && view_l[k] && view_r[k])
            |=> !view_l[k]); // R9

        AST_RIGHT_HOLD_KEPT: assert property (@(posedge clk) disable iff (rst)
            (!view_r[k] && !(acc_r && wr_r && wd0_r && idx_r == IDX_W'(k)))
            |=> !view_r[k]); // R6

        AST_LEFT_HOLD_KEPT: assert property (@(posedge clk) disable iff (rst)
            (!view_l[k] && !(acc_l && wr_l && wd0_l && idx_l == IDX_W'(k)))
            |=> !view_l[k]); // R6
    end
endmodule

bind semb_bank semb_chk #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst(rst),
    .acc_l(sel_l & ~mem_en_l), .wr_l(wr_l), .idx_l(addr_l[IDX_W-1:0]), .wd0_l(wdata_l[0]),
    .acc_r(sel_r & ~mem_en_r), .wr_r(wr_r), .idx_r(addr_r[IDX_W-1:0]), .wd0_r(wdata_r[0]),
    .view_l(sem_view_l), .view_r(sem_view_r), .rdata_l(rdata_l), .rdata_r(rdata_r)
);

// File: tb/semb_bank_tb_top.sv
module semb_bank_tb_top;
    localparam int N  = 8;
    localparam int AW = 14;
    localparam int DW = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_l = 1'b0, mem_en_l = 1'b0, wr_l = 1'b0;
    logic sel_r = 1'b0, mem_en_r = 1'b0, wr_r = 1'b0;
    logic [AW-1:0] addr_l = '0, addr_r = '0;
    logic [DW-1:0] wdata_l = '0, wdata_r = '0;
    logic [DW-1:0] rdata_l, rdata_r;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // model: 0 free, 1 left holds, 2 right holds
    int own [N];
    bit pl [N];
    bit pr [N];

    always #4 clk = ~clk;

    semb_bank #(.NUM_SEM(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst),
        .sel_l(sel_l), .mem_en_l(mem_en_l), .wr_l(wr_l), .addr_l(addr_l),
        .wdata_l(wdata_l), .rdata_l(rdata_l),
        .sel_r(sel_r), .mem_en_r(mem_en_r), .wr_r(wr_r), .addr_r(addr_r),
        .wdata_r(wdata_r), .rdata_r(rdata_r)
    );

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step(input bit lw, input int li, input bit ld,
                              input bit rw, input int ri, input bit rd);
        for (int k = 0; k < N; k++) begin
            bit tl, dl, tr, dr;
            tl = lw && li == k && !ld;  dl = lw && li == k && ld;
            tr = rw && ri == k && !rd;  dr = rw && ri == k && rd;
            if (own[k] == 0) begin
                pl[k] = 0; pr[k] = 0;
                if (tl) begin own[k] = 1; pr[k] = tr; end
                else if (tr) own[k] = 2;
            end else if (own[k] == 1) begin
                if (tr) pr[k] = 1; else if (dr) pr[k] = 0;
                if (dl) begin
                    if (pr[k]) begin own[k] = 2; pr[k] = 0; end
                    else own[k] = 0;
                end
            end else begin
                if (tl) pl[k] = 1; else if (dl) pl[k] = 0;
                if (dr) begin
                    if (pl[k]) begin own[k] = 1; pl[k] = 0; end
                    else own[k] = 0;
                end
            end
        end
    endtask

    task automatic drive(input bit ls, input bit lm, input bit lw, input logic [AW-1:0] la,
                         input logic [DW-1:0] ld, input bit rs, input bit rm, input bit rw,
                         input logic [AW-1:0] ra, input logic [DW-1:0] rd);
        @(negedge clk);
        sel_l = ls; mem_en_l = lm; wr_l = lw; addr_l = la; wdata_l = ld;
        sel_r = rs; mem_en_r = rm; wr_r = rw; addr_r = ra; wdata_r = rd;
        @(posedge clk);
        #1;
        model_step(ls && !lm && lw, int'(la[2:0]), ld[0], rs && !rm && rw, int'(ra[2:0]), rd[0]);
    endtask

    task automatic idle();
        drive(0, 0, 0, '0, '0, 0, 0, 0, '0, '0);
    endtask

    // read the same index from both sides and compare with the model
    task automatic rd_both(input int idx, input logic [AW-1:0] hi, input string tag);
        logic [DW-1:0] el, er;
        el = {DW{own[idx] != 1}};
        er = {DW{own[idx] != 2}};
        drive(1, 0, 0, hi | AW'(idx), '0, 1, 0, 0, hi | AW'(idx), '0);
        check(rdata_l === el, {tag, " left"}, rdata_l, el);
        check(rdata_r === er, {tag, " right"}, rdata_r, er);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        for (int k = 0; k < N; k++) begin own[k] = 0; pl[k] = 0; pr[k] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(rdata_l === '1, "R1 rdata_l after reset", rdata_l, '1);
        check(rdata_r === '1, "R1 rdata_r after reset", rdata_r, '1);
        for (int k = 0; k < N; k++) rd_both(k, '0, "R1 free sweep");

        // R5 + R3: left takes 3 with junk in high address bits
        drive(1, 0, 1, 14'h3FF8 | 14'd3, 9'h000, 0, 0, 0, '0, '0);
        rd_both(3, 14'h1230, "R5 R3 left takes");
        // R6 + R4: right asks with all other data bits set
        drive(0, 0, 0, '0, '0, 1, 0, 1, 14'd3, 9'h1FE);
        rd_both(3, '0, "R6 R4 non-holder write");
        // R7: left releases, queued right gets it
        drive(1, 0, 1, 14'd3, 9'h001, 0, 0, 0, '0, '0);
        rd_both(3, '0, "R7 queued grant");
        // R8: right releases, free
        drive(0, 0, 0, '0, '0, 1, 0, 1, 14'h2003, 9'h0FF);
        rd_both(3, '0, "R8 free after release");

        // R9 tie
        drive(1, 0, 1, 14'd5, 9'h000, 1, 0, 1, 14'd5, 9'h000);
        rd_both(5, '0, "R9 tie goes left");
        drive(1, 0, 1, 14'd5, 9'h001, 0, 0, 0, '0, '0);
        rd_both(5, '0, "R9 right queued after tie");
        drive(0, 0, 0, '0, '0, 1, 0, 1, 14'd5, 9'h001);

        // R10 withdrawn request
        drive(1, 0, 1, 14'd6, 9'h000, 0, 0, 0, '0, '0);
        drive(0, 0, 0, '0, '0, 1, 0, 1, 14'd6, 9'h000);
        drive(0, 0, 0, '0, '0, 1, 0, 1, 14'd6, 9'h001);
        drive(1, 0, 1, 14'd6, 9'h001, 0, 0, 0, '0, '0);
        rd_both(6, '0, "R10 withdrawn then freed");

        // R2 blocked accesses
        drive(1, 1, 1, 14'd0, 9'h000, 0, 0, 1, 14'd0, 9'h000);
        rd_both(0, '0, "R2 blocked writes");
        drive(1, 0, 1, 14'd2, 9'h000, 0, 0, 0, '0, '0);
        rd_both(2, '0, "R2 left holds 2");
        drive(1, 1, 0, 14'd7, '0, 0, 0, 0, 14'd7, '0);
        check(rdata_l === '0, "R2 rdata_l held on blocked read", rdata_l, '0);
        check(rdata_r === '1, "R2 rdata_r held on deselected read", rdata_r, '1);

        // R11: read captures pre-write state and holds across writes
        drive(1, 0, 0, 14'd4, '0, 1, 0, 1, 14'd4, 9'h000);
        check(rdata_l === '1, "R11 read sees state before same-cycle write", rdata_l, '1);
        drive(1, 0, 1, 14'd4, 9'h000, 1, 0, 1, 14'd4, 9'h001);
        check(rdata_l === '1, "R11 rdata_l unchanged by writes", rdata_l, '1);
        rd_both(4, '0, "R11 after handoff");

        // R13 simultaneous release and request
        drive(1, 0, 1, 14'd7, 9'h000, 0, 0, 0, '0, '0);
        drive(1, 0, 1, 14'd7, 9'h001, 1, 0, 1, 14'd7, 9'h000);
        rd_both(7, '0, "R13 same-cycle handoff");

        // R12 all indices still match
        for (int k = 0; k < N; k++) rd_both(k, 14'h0AA8, "R12 independence");

        // sweep of mixed operations on indices 0..3
        lf = 16'hACE1;
        for (int s = 0; s < 600; s++) begin
            logic [15:0] lb;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            lb = {lf[7:0], lf[15:8]} ^ 16'h5A3C;
            drive(lf[0] | lf[1], lf[2] & lf[3], ~(lf[4] & lf[5]), {lf[15:5], 1'b0, lf[7:6]},
                  {lf[12:5], lf[9]},
                  lb[0] | lb[1], lb[2] & lb[3], ~(lb[4] & lb[5]), {lb[15:5], 1'b0, lb[7:6]},
                  {lb[12:5], lb[11]});
            rd_both(int'(lf[7:6]), '0, "R7 R10 R13 sweep");
        end
        for (int k = 0; k < N; k++) rd_both(k, '0, "R12 final sweep");

        idle();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule